// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes an incoming Ethernet frame as a byte stream and lays it into a circular receive area of local packet memory. The area is organised as 256-byte pages bounded by a start page and a stop page. Every stored frame gets a 4-byte header placed at the front of its first page. The header carries a status byte, a link to the page where the following frame will begin, and the stored length. The host driver walks this chain of links and uses its boundary page to tell the block how far it has read.

Before a frame is stored, the block checks whether it can be accepted at all. A frame is refused if the receiver has been stopped, if the ring limits are not usable, or if a maximum-size frame would not fit between the current page and the boundary. When a frame is refused, the rest of its bytes are taken in and thrown away. When a frame is accepted, the data is written first, beginning four bytes into the current page, and it wraps from the stop page back to the start page. Frames under the minimum length are padded with zeros. Once the last byte is in, the header is written, and then the new current page is handed back together with a receive-done pulse.

Top module: `rx_ring_writer`

## Requirements
- R1: During and after reset, no memory write, current-page update or done pulse is issued, and `in_ready` is high.
- R2: A frame that starts while `stop_cmd` is high is refused: it causes no memory write and no current-page update, and its bytes are consumed.
- R3: A frame is refused when `stop_pg` is less than or equal to `start_pg`.
- R4: Free space in bytes is 256×(bnd_pg−cur_pg) when cur_pg < bnd_pg, and otherwise 256×((stop_pg−start_pg)−(cur_pg−bnd_pg)). A frame is refused when the free space is below MAX_FRAME+4 (1518 by default).
- R5: Frame byte k is written to byte address base×256+4+k, where base is the starting page. When the incremented address equals stop_pg×256, writing continues at start_pg×256.
- R6: A frame shorter than MIN_FRAME (60) bytes is followed by zero bytes until MIN_FRAME bytes have been stored.
- R7: After the data, four header bytes are written at base×256+0..3, in this order: the status byte (0x01, ORed with 0x20 when bit 0 of the first frame byte is 1), the next page, bits 7:0 of the total length, and bits 15:8 of the total length. The total length is the stored length plus 4.
- R8: The next page is base + ceil((stored length + 8)/256). When this is at or beyond stop_pg, (stop_pg − start_pg) is subtracted from it.
- R9: One cycle after the last header write, `cur_we` and `rx_done` pulse high for one cycle, with `cur_val` equal to the next page.
- R10: When cur_pg ≥ MEM_END_PG (0xC0), the frame is stored starting at start_pg and not at cur_pg.
- R11: `in_ready` goes low from the cycle after an accepted frame's last byte until the update in R9. It stays high for refused frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_cmd | input | 1 | Receiver stopped; refuse new frames |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | Page just past the end of the ring |
| bnd_pg | input | 8 | Host read boundary page |
| cur_pg | input | 8 | Current write page |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Block can take a byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write byte |
| cur_we | output | 1 | Load strobe for the current page |
| cur_val | output | 8 | New current page |
| rx_done | output | 1 | Receive-complete pulse for interrupt status |

## Verification
The bench uses the default parameters: 8-bit page numbers, a 1514-byte maximum frame, a 60-byte minimum and a memory end at page 0xC0. It sets up a small 16-page ring from 0x40 up to 0x50. With a ring this small, a single 300-byte frame is enough to cross the ring end, and the free-space limit of six pages lies within a few pages of the boundary, so both sides of it can be tested. A current page above 0xC0 exercises the fallback to the start page. Frame lengths of 248 and 249 bytes fall on either side of a page step in the next-page calculation.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_HDR,
    ST_FIN
  } rxr_state_e;

  localparam int HDR_LEN = 4;
endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
  parameter int PG_W      = 8,
  parameter int MAX_FRAME = 1514
) (
  input  logic            stop_cmd,
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] cur_pg,
  output logic            accept
);
  localparam int PW = PG_W + 2;
  localparam int BW = PW + 8;
  localparam logic signed [BW-1:0] NEED_B = BW'(MAX_FRAME + 4);

  logic signed [PW-1:0] ring_p, free_p;
  logic signed [BW-1:0] free_b;

  always_comb begin
    ring_p = $signed(PW'(stop_pg)) - $signed(PW'(start_pg));
    if (cur_pg < bnd_pg)
      free_p = $signed(PW'(bnd_pg)) - $signed(PW'(cur_pg));
    else
      free_p = ring_p - ($signed(PW'(cur_pg)) - $signed(PW'(bnd_pg)));
    free_b = $signed({free_p, 8'h00});
    accept = !stop_cmd && (stop_pg > start_pg) && !(free_b < NEED_B);
  end
endmodule

// File: rtl/rxr_next_pg.sv
module rxr_next_pg #(
  parameter int PG_W  = 8,
  parameter int LEN_W = 16
) (
  input  logic [PG_W-1:0]  base_pg,
  input  logic [PG_W-1:0]  start_pg,
  input  logic [PG_W-1:0]  stop_pg,
  input  logic [LEN_W-1:0] stored_len,
  output logic [PG_W-1:0]  next_pg
);
  localparam int SW = LEN_W + 2;

  logic [SW-1:0] pages, sum, ring;

  always_comb begin
    // header (4) plus trailing checksum room (4), rounded up to whole pages
    pages = (SW'(stored_len) + SW'(8 + 255)) >> 8;
    sum   = SW'(base_pg) + pages;
    ring  = SW'(stop_pg) - SW'(start_pg);
    if (sum >= SW'(stop_pg))
      next_pg = PG_W'(sum - ring);
    else
      next_pg = PG_W'(sum);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PG_W       = 8,
  parameter int LEN_W      = 16,
  parameter int MAX_FRAME  = 1514,
  parameter int MIN_FRAME  = 60,
  parameter int MEM_END_PG = 192
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stop_cmd,
  input  logic [PG_W-1:0]      start_pg,
  input  logic [PG_W-1:0]      stop_pg,
  input  logic [PG_W-1:0]      bnd_pg,
  input  logic [PG_W-1:0]      cur_pg,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic                 mem_we,
  output logic [PG_W+7:0]      mem_addr,
  output logic [7:0]           mem_wdata,
  output logic                 cur_we,
  output logic [PG_W-1:0]      cur_val,
  output logic                 rx_done
);
  localparam int ADDR_W = PG_W + 8;
  localparam logic [PG_W:0]    END_PG  = (PG_W+1)'(MEM_END_PG);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  rxr_state_e        state;
  logic [PG_W-1:0]   start_q, stop_q, base_q;
  logic [ADDR_W-1:0] wr_addr;
  logic [LEN_W-1:0]  len_q;
  logic              mcast_q;
  logic [1:0]        hdr_idx;

  logic              accept;
  logic [PG_W-1:0]   base_sel, next_pg;
  logic [ADDR_W-1:0] first_addr;
  logic [LEN_W-1:0]  len_inc, total_len;

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic [PG_W-1:0]   s,
    input logic [PG_W-1:0]   e
  );
    logic [ADDR_W-1:0] n;
    n = a + 1'b1;
    return (n == {e, 8'h00}) ? {s, 8'h00} : n;
  endfunction

  rxr_space_chk #(.PG_W(PG_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .stop_cmd (stop_cmd),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .bnd_pg   (bnd_pg),
    .cur_pg   (cur_pg),
    .accept   (accept)
  );

  rxr_next_pg #(.PG_W(PG_W), .LEN_W(LEN_W)) u_next (
    .base_pg    (base_q),
    .start_pg   (start_q),
    .stop_pg    (stop_q),
    .stored_len (len_q),
    .next_pg    (next_pg)
  );

  assign base_sel   = ({1'b0, cur_pg} >= END_PG) ? start_pg : cur_pg;
  assign first_addr = {base_sel, 8'h04};
  assign len_inc    = len_q + 1'b1;
  assign total_len  = len_q + LEN_W'(HDR_LEN);
  assign in_ready   = (state == ST_IDLE) || (state == ST_DATA) || (state == ST_DROP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      start_q   <= '0;
      stop_q    <= '0;
      base_q    <= '0;
      wr_addr   <= '0;
      len_q     <= '0;
      mcast_q   <= 1'b0;
      hdr_idx   <= 2'd0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cur_we    <= 1'b0;
      cur_val   <= '0;
      rx_done   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      cur_we  <= 1'b0;
      rx_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid && in_sof) begin
            if (accept) begin
              start_q   <= start_pg;
              stop_q    <= stop_pg;
              base_q    <= base_sel;
              mcast_q   <= in_data[0];
              mem_we    <= 1'b1;
              mem_addr  <= first_addr;
              mem_wdata <= in_data;
              wr_addr   <= step_addr(first_addr, start_pg, stop_pg);
              len_q     <= LEN_W'(1);
              hdr_idx   <= 2'd0;
              if (!in_eof)
                state <= ST_DATA;
              else if (LEN_W'(1) < MIN_LEN)
                state <= ST_PAD;
              else
                state <= ST_HDR;
            end else if (!in_eof) begin
              state <= ST_DROP;
            end
          end
        end
        ST_DATA: begin
          if (in_valid) begin
            mem_we    <= 1'b1;
            mem_addr  <= wr_addr;
            mem_wdata <= in_data;
            wr_addr   <= step_addr(wr_addr, start_q, stop_q);
            len_q     <= len_inc;
            if (in_eof)
              state <= (len_inc < MIN_LEN) ? ST_PAD : ST_HDR;
          end
        end
        ST_DROP: begin
          if (in_valid && in_eof)
            state <= ST_IDLE;
        end
        ST_PAD: begin
          mem_we    <= 1'b1;
          mem_addr  <= wr_addr;
          mem_wdata <= 8'h00;
          wr_addr   <= step_addr(wr_addr, start_q, stop_q);
          len_q     <= len_inc;
          if (len_inc >= MIN_LEN)
            state <= ST_HDR;
        end
        ST_HDR: begin
          mem_we   <= 1'b1;
          mem_addr <= {base_q, 6'd0, hdr_idx};
          case (hdr_idx)
            2'd0:    mem_wdata <= mcast_q ? 8'h21 : 8'h01;
            2'd1:    mem_wdata <= 8'(next_pg);
            2'd2:    mem_wdata <= total_len[7:0];
            default: mem_wdata <= total_len[15:8];
          endcase
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_idx == 2'd3)
            state <= ST_FIN;
        end
        ST_FIN: begin
          cur_we  <= 1'b1;
          cur_val <= next_pg;
          rx_done <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REFUSE_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && in_valid && in_sof && stop_cmd) |=> !mem_we); // R2
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_PAD) |-> (mem_we && mem_wdata == 8'h00)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done); // R9
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !mem_we); // R9
  AST_NEXT_IN_RING: assert property (@(posedge clk) disable iff (rst)
    (cur_we && base_q >= start_q && base_q < stop_q)
      |-> (cur_val >= start_q && cur_val < stop_q)); // R8
endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int END_PG = 192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_cmd = 1'b0;
  logic [7:0] start_pg = 8'h40, stop_pg = 8'h50, bnd_pg = 8'h40, cur_pg = 8'h40;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, mem_we, cur_we, rx_done;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, cur_val;

  int checks = 0, failures = 0, done_cnt = 0;
  int exp_addr[$], exp_data[$];
  string exp_tag[$];
  int exp_cur[$];
  bit finished = 0;

  always #10 clk = ~clk;

  rx_ring_writer u_dut (
    .clk(clk), .rst(rst), .stop_cmd(stop_cmd), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .cur_pg(cur_pg), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_ready(in_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_we(cur_we), .cur_val(cur_val),
    .rx_done(rx_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference queues
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        if (exp_addr.size() == 0) begin
          check(0, "R5 unexpected write", int'(mem_addr), -1);
        end else begin
          automatic int a = exp_addr.pop_front();
          automatic int d = exp_data.pop_front();
          automatic string t = exp_tag.pop_front();
          check(int'(mem_addr) == a && int'(mem_wdata) == d,
                {t, " write addr/data"}, int'({mem_addr, mem_wdata}), (a << 8) | d);
        end
      end
      check(rx_done == cur_we, "R9 done with update", int'(rx_done), int'(cur_we));
      if (cur_we) begin
        done_cnt++;
        if (exp_cur.size() == 0) begin
          check(0, "R9 unexpected update", int'(cur_val), -1);
        end else begin
          automatic int c = exp_cur.pop_front();
          check(int'(cur_val) == c, "R8 next page", int'(cur_val), c);
          check(exp_addr.size() == 0, "R9 update after header", exp_addr.size(), 0);
        end
        cur_pg = cur_val;
      end
    end
  end

  task automatic run_frame(input int n, input int first, input string rtag);
    int b[$];
    int ring, avail, base, len, addr, nxt, d0;
    bit acc;
    for (int i = 0; i < n; i++) b.push_back(i == 0 ? first : ((i * 7 + 3) & 255));
    ring = int'(stop_pg) - int'(start_pg);
    if (cur_pg < bnd_pg) avail = (int'(bnd_pg) - int'(cur_pg)) * 256;
    else avail = ring * 256 - (int'(cur_pg) - int'(bnd_pg)) * 256;
    acc = !stop_cmd && (stop_pg > start_pg) && (avail >= 1518);
    if (acc) begin
      base = (int'(cur_pg) >= END_PG) ? int'(start_pg) : int'(cur_pg);
      len = (n < 60) ? 60 : n;
      addr = base * 256 + 4;
      for (int i = 0; i < len; i++) begin
        exp_addr.push_back(addr);
        exp_data.push_back(i < n ? b[i] : 0);
        exp_tag.push_back(i < n ? "R5" : "R6");
        addr++;
        if (addr == int'(stop_pg) * 256) addr = int'(start_pg) * 256;
      end
      nxt = base * 256 + ((len + 8 + 255) / 256) * 256;
      if (nxt >= int'(stop_pg) * 256) nxt -= ring * 256;
      nxt = nxt / 256;
      d0 = (first & 1) ? 8'h21 : 8'h01;
      exp_addr.push_back(base * 256);     exp_data.push_back(d0);                     exp_tag.push_back("R7");
      exp_addr.push_back(base * 256 + 1); exp_data.push_back(nxt);                    exp_tag.push_back("R7");
      exp_addr.push_back(base * 256 + 2); exp_data.push_back((len + 4) & 255);        exp_tag.push_back("R7");
      exp_addr.push_back(base * 256 + 3); exp_data.push_back(((len + 4) >> 8) & 255); exp_tag.push_back("R7");
      exp_cur.push_back(nxt);
    end
    begin
      automatic int dc0 = done_cnt;
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = 8'(b[i]);
      end
      @(negedge clk);
      check(in_ready == !acc, "R11 ready after last byte", int'(in_ready), int'(!acc));
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      while (!in_ready) @(negedge clk);
      repeat (3) @(negedge clk);
      check(exp_addr.size() == 0, {rtag, " pending writes"}, exp_addr.size(), 0);
      check(done_cnt - dc0 == int'(acc), {rtag, " completions"}, done_cnt - dc0, int'(acc));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mem_we && !cur_we && !rx_done, "R1 outputs in reset",
          int'({mem_we, cur_we, rx_done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready && !mem_we && !cur_we && !rx_done, "R1 state after reset",
          int'({in_ready, mem_we, cur_we, rx_done}), 8);

    run_frame(64, 8'h10, "R7");                       // -> 0x41
    run_frame(10, 8'h01, "R6");                       // padded, status 0x21
    run_frame(60, 8'h02, "R6");                       // exactly minimum
    run_frame(248, 8'h04, "R8");                      // one page
    run_frame(249, 8'h06, "R8");                      // two pages
    cur_pg = 8'h4F; bnd_pg = 8'h4F;
    run_frame(300, 8'h08, "R5");                      // wraps, next 0x41
    cur_pg = 8'h41; bnd_pg = 8'h46;
    run_frame(100, 8'h0A, "R4");                      // 5 pages free: refused
    check(cur_pg == 8'h41, "R4 current page kept", int'(cur_pg), 8'h41);
    bnd_pg = 8'h47;
    run_frame(100, 8'h0C, "R4");                      // 6 pages free: accepted
    stop_cmd = 1'b1;
    run_frame(20, 8'h0E, "R2");
    stop_cmd = 1'b0;
    stop_pg = 8'h40;
    run_frame(20, 8'h12, "R3");
    start_pg = 8'h50; stop_pg = 8'h48;
    run_frame(1, 8'h14, "R3");
    start_pg = 8'h40; stop_pg = 8'h50;
    cur_pg = 8'hC5; bnd_pg = 8'hC5;
    run_frame(70, 8'h16, "R10");                      // stored at start page
    check(cur_pg == 8'h41, "R10 next from start page", int'(cur_pg), 8'h41);
    bnd_pg = 8'h41;
    run_frame(1, 8'hFF, "R6");                        // single byte, multicast bit
    cur_pg = 8'h40; bnd_pg = 8'h40;
    run_frame(1514, 8'h20, "R8");                     // maximum frame, 6 pages
    check(cur_pg == 8'h46, "R8 maximum frame pages", int'(cur_pg), 8'h46);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule